// File: doc/BRIEF.md
# Two-State Bus Cycle Sequencer

This block is the bus-master sequencer of a processor-style external bus. An internal requester offers one bus cycle at a time, described by a cycle kind, a word address, byte enables, write data and a lock flag. The sequencer turns each request into an address state followed by one or more data states. It raises an address strobe together with the address and three status lines. It waits for the ready input before it ends a data state, and returns completion and read data to the requester.

The block runs from a double-rate clock `clk2`. Each bus state spans two `clk2` periods, phase one and phase two. All bus and request inputs are sampled only on the edge that closes phase two. A next-address input lets the following cycle's address be issued while the current data state is still waiting, so the two cycles overlap. A lock output keeps a read-modify-write sequence together. A hold request is acknowledged only between cycles, and the bus is then left idle until hold is released.

Top module: `bus_cycle_seq`

## Requirements
- R1: `phase2` is 0 while reset is applied and inverts on every rising edge of `clk2` after that. A bus state is one phase-one period followed by one phase-two period. `bus_ready`, `bus_na`, `bus_hold` and `req_valid` are used only on the rising edge that ends a phase-two period (the state end), and the values they take during phase one have no effect.
- R2: While reset is applied, and after it, `ads`, `bus_lock`, `bus_hlda`, `done`, `req_accept` and `bus_wen` are 0. With no request and no hold, the sequencer stays idle and `ads` stays 0.
- R3: At a state end in idle, or at the completion of a data state, with `req_valid` high and no granted hold, `req_accept` is high during that phase two. The next bus state is the address state: `ads` is 1 for exactly that one bus state, and `bus_addr` and `bus_be` show the request. A data state always follows an address state. Address and byte enables hold until the next accept.
- R4: `req_kind` selects the status lines {`bus_mio`,`bus_dc`,`bus_wr`} as follows: 0 memory read gives 110, 1 memory write gives 111, 2 I/O read gives 010, 3 I/O write gives 011, 4 code fetch gives 100, 5 interrupt acknowledge gives 000, 6 halt gives 101, and 7 is run as a memory read (110).
- R5: A data state that ends with `bus_ready` low is followed by another data state. In that state the address, status and write data are unchanged and `done` stays 0.
- R6: `bus_ready` high at the end of a data state completes the cycle, and `done` is 1 for the bus state that follows. For kinds 0, 2, 4, 5 and 7, `rdata` takes the `bus_rdata` value sampled on that edge. For the other kinds `rdata` keeps its previous value.
- R7: `bus_wen` is 1 exactly during the data states of kinds 1 and 3. `bus_wdata` then carries that cycle's write data, and this also holds while a pipelined next address is on the bus.
- R8: `bus_na` high, `req_valid` high and `bus_ready` low at the end of a data state cause an accept. The next state shows `ads` with the new address and status while the current data state continues. When the current cycle completes, the new cycle goes straight to a data state without a separate address state. `bus_na` has no effect in any other case.
- R9: Accepting a request with `req_lock` set to 1 raises `bus_lock` from its address state onward. `bus_lock` stays high until a cycle accepted with `req_lock` set to 0 completes while no locked pipelined cycle is pending. No hold is granted while the lock is held.
- R10: `bus_hold` sampled high, with the lock clear, at a state end in idle or at the completion of a non-pipelined data state, puts `bus_hlda` at 1 from the next state. It takes precedence over a pending request. No strobe and no accept are given while `bus_hlda` is 1, and the sequencer returns to idle at the first state end where `bus_hold` is low. A cycle whose address was issued early runs to its end without regard to hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester offers a cycle |
| req_kind | input | 3 | Cycle kind code (see R4) |
| req_addr | input | ADDR_W | Word address of the cycle |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| req_lock | input | 1 | Keep the bus locked after this cycle |
| req_accept | output | 1 | Request taken at this state end |
| done | output | 1 | Previous cycle completed |
| rdata | output | DATA_W | Last captured read data |
| phase2 | output | 1 | High during the second phase of a bus state |
| ads | output | 1 | Address strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | DATA_W/8 | Bus byte enables |
| bus_mio | output | 1 | 1 = memory, 0 = I/O |
| bus_dc | output | 1 | 1 = data, 0 = control |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_lock | output | 1 | Bus locked across a sequence |
| bus_ready | input | 1 | Ends the current data state |
| bus_na | input | 1 | Next address may be issued |
| bus_hold | input | 1 | Other master asks for the bus |
| bus_hlda | output | 1 | Bus handed over |
| bus_wdata | output | DATA_W | Write data on the bus |
| bus_wen | output | 1 | Write data driven |
| bus_rdata | input | DATA_W | Read data from the bus |

## Verification
The bench first runs back-to-back cycles with ready always high, which shows that each cycle is exactly one address state plus one data state. It then runs long stretches with sparse ready and frequent next-address, which separates true pipelined overlap from plain wait states, and a stretch with heavy hold traffic, which shows whether hold is granted only at legal boundaries and never under lock. Random values on ready, next-address and hold during phase one show whether any input is wrongly sampled mid-state. Random kinds and lock flags cover every status code, including the spare code, and the locked sequences that block hold.

// File: rtl/bus_seq_pkg.sv
// Package: shared types for the bus cycle sequencer.
// Assumes: a 3-bit cycle kind from the requester, codes fixed by the brief.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        KIND_MEM_RD  = 3'd0,
        KIND_MEM_WR  = 3'd1,
        KIND_IO_RD   = 3'd2,
        KIND_IO_WR   = 3'd3,
        KIND_CODE_RD = 3'd4,
        KIND_INT_ACK = 3'd5,
        KIND_HALT    = 3'd6,
        KIND_SPARE   = 3'd7
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ADDR      = 3'd1,
        ST_DATA      = 3'd2,
        ST_DATA_NEXT = 3'd3,
        ST_HELD      = 3'd4
    } seq_state_t;

    // True for kinds that drive write data in their data states.
    function automatic logic kind_is_write(cyc_kind_t k);
        return (k == KIND_MEM_WR) || (k == KIND_IO_WR);
    endfunction

    // True for kinds that return data at completion (halt returns none).
    function automatic logic kind_is_read(cyc_kind_t k);
        return !(kind_is_write(k) || (k == KIND_HALT));
    endfunction

endpackage

// File: rtl/bus_phase_gen.sv
// Module: bus_phase_gen
// Divides clk2 into the two phases of a bus state. phase2 high marks the
// second clk2 period; the rising edge that ends it is the state end.
// Assumes: synchronous active-low reset, phase one follows reset.
module bus_phase_gen (
    input  logic clk2,
    input  logic rst_n,
    output logic phase2
);

    // Toggle the phase on every clk2 edge.
    always_ff @(posedge clk2) begin
        if (!rst_n) phase2 <= 1'b0;
        else        phase2 <= ~phase2;
    end

    // R1: the phase alternates on every edge once out of reset.
    assert_phase_alternates_R1: assert property (@(posedge clk2) disable iff (!rst_n)
        $past(rst_n) |-> (phase2 != $past(phase2)));

endmodule

// File: rtl/bus_status_enc.sv
// Module: bus_status_enc
// Maps a cycle kind onto the memory/IO, data/control and write/read lines.
// Assumes: the spare kind code runs as a memory data read.
module bus_status_enc
    import bus_seq_pkg::*;
(
    input  cyc_kind_t kind,
    output logic      mio,
    output logic      dc,
    output logic      wr
);

    // Decode the kind into the three status lines.
    always_comb begin
        unique case (kind)
            KIND_MEM_RD:  {mio, dc, wr} = 3'b110;
            KIND_MEM_WR:  {mio, dc, wr} = 3'b111;
            KIND_IO_RD:   {mio, dc, wr} = 3'b010;
            KIND_IO_WR:   {mio, dc, wr} = 3'b011;
            KIND_CODE_RD: {mio, dc, wr} = 3'b100;
            KIND_INT_ACK: {mio, dc, wr} = 3'b000;
            KIND_HALT:    {mio, dc, wr} = 3'b101;
            default:      {mio, dc, wr} = 3'b110;
        endcase
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
// Module: bus_cycle_ctrl
// Bus state machine: idle, address state, data state, data state with the
// next address already issued, and held. Decides accepts, completion,
// lock and hold grant. Every decision is taken at a state end.
// Assumes: phase2 from bus_phase_gen; lock flags come from the datapath.
module bus_cycle_ctrl
    import bus_seq_pkg::*;
(
    input  logic clk2,
    input  logic rst_n,
    input  logic phase2,
    input  logic req_valid,
    input  logic req_lock,
    input  logic ready,
    input  logic na,
    input  logic hold,
    input  logic a_lock,
    input  logic d_lock,
    output logic load_a,
    output logic load_d,
    output logic complete,
    output logic in_data,
    output logic ads,
    output logic lock,
    output logic hlda,
    output logic done
);

    seq_state_t st, st_nxt;
    logic       lk, lk_after, lk_nxt, grant;

    // Data states are the plain one and the overlapped one.
    always_comb in_data = (st == ST_DATA) || (st == ST_DATA_NEXT);

    // A cycle completes when ready is seen at the end of a data state.
    always_comb complete = phase2 && in_data && ready;

    // Lock value once this edge's completion is taken into account.
    always_comb begin
        lk_after = lk;
        if (complete && !d_lock && !((st == ST_DATA_NEXT) && a_lock))
            lk_after = 1'b0;
    end

    // Hold is granted only when no lock remains.
    always_comb grant = hold && !lk_after;

    // Next state and load strobes, evaluated at state ends only.
    always_comb begin
        st_nxt = st;
        load_a = 1'b0;
        load_d = 1'b0;
        if (phase2) begin
            case (st)
                ST_IDLE: begin
                    if (grant) st_nxt = ST_HELD;
                    else if (req_valid) begin
                        load_a = 1'b1;
                        st_nxt = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    load_d = 1'b1;
                    st_nxt = ST_DATA;
                end
                ST_DATA: begin
                    if (ready) begin
                        if (grant) st_nxt = ST_HELD;
                        else if (req_valid) begin
                            load_a = 1'b1;
                            st_nxt = ST_ADDR;
                        end else st_nxt = ST_IDLE;
                    end else if (na && req_valid) begin
                        load_a = 1'b1;
                        st_nxt = ST_DATA_NEXT;
                    end
                end
                ST_DATA_NEXT: begin
                    if (ready) begin
                        load_d = 1'b1;
                        st_nxt = ST_DATA;
                    end
                end
                ST_HELD: begin
                    if (!hold) st_nxt = ST_IDLE;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // Lock is set by a locked accept, otherwise follows the completion rule.
    always_comb lk_nxt = (load_a && req_lock) ? 1'b1 : lk_after;

    // State, lock, strobe and completion registers advance at state ends.
    always_ff @(posedge clk2) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            lk   <= 1'b0;
            ads  <= 1'b0;
            done <= 1'b0;
        end else if (phase2) begin
            st   <= st_nxt;
            lk   <= lk_nxt;
            ads  <= load_a;
            done <= complete;
        end
    end

    // Drive the lock and hold acknowledge lines from state.
    always_comb begin
        lock = lk;
        hlda = (st == ST_HELD);
    end

    // R1: bus-side outputs change only on state ends.
    assert_outputs_state_aligned_R1: assert property (@(posedge clk2) disable iff (!rst_n)
        !phase2 |=> $stable({ads, done, lock, hlda}));

    // R2: an idle bus carries no strobe.
    assert_idle_no_strobe_R2: assert property (@(posedge clk2) disable iff (!rst_n)
        (st == ST_IDLE) |-> !ads);

    // R5: a data state without ready is followed by another data state.
    assert_wait_stays_data_R5: assert property (@(posedge clk2) disable iff (!rst_n)
        (in_data && phase2 && !ready) |=> in_data);

    // R6: completion is reported only after a data state.
    assert_done_after_data_R6: assert property (@(posedge clk2) disable iff (!rst_n)
        $rose(done) |-> $past(in_data));

    // R8: the overlapped data state needs next-address.
    assert_pipe_needs_na_R8: assert property (@(posedge clk2) disable iff (!rst_n)
        ((st == ST_DATA) && phase2 && !na) |=> (st != ST_DATA_NEXT));

    // R9, R10: the handed-over bus is unlocked and carries no strobe.
    assert_held_bus_quiet_R10: assert property (@(posedge clk2) disable iff (!rst_n)
        hlda |-> (!ads && !lock && !load_a));

endmodule

// File: rtl/bus_cycle_datapath.sv
// Module: bus_cycle_datapath
// Holds the address-side record (what is on the address lines) and the
// data-side record (the cycle in its data state), drives write data and
// captures read data at completion.
// Assumes: load_a and load_d never fire on the same edge.
module bus_cycle_datapath
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk2,
    input  logic              rst_n,
    input  logic              phase2,
    input  logic              load_a,
    input  logic              load_d,
    input  logic              complete,
    input  logic              in_data,
    input  logic              ads,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_lock,
    input  logic [DATA_W-1:0] bus_rdata,
    output cyc_kind_t         a_kind,
    output logic              a_lock,
    output logic              d_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wen,
    output logic [DATA_W-1:0] rdata
);

    cyc_kind_t         d_kind;
    logic [DATA_W-1:0] a_wdata;

    // Address-side record: loaded when a request is accepted.
    always_ff @(posedge clk2) begin
        if (!rst_n) begin
            a_kind   <= KIND_MEM_RD;
            a_lock   <= 1'b0;
            bus_addr <= '0;
            bus_be   <= '0;
            a_wdata  <= '0;
        end else if (load_a) begin
            a_kind   <= cyc_kind_t'(req_kind);
            a_lock   <= req_lock;
            bus_addr <= req_addr;
            bus_be   <= req_be;
            a_wdata  <= req_wdata;
        end
    end

    // Data-side record: copied from the address side on entering data.
    always_ff @(posedge clk2) begin
        if (!rst_n) begin
            d_kind    <= KIND_MEM_RD;
            d_lock    <= 1'b0;
            bus_wdata <= '0;
        end else if (load_d) begin
            d_kind    <= a_kind;
            d_lock    <= a_lock;
            bus_wdata <= a_wdata;
        end
    end

    // Read data captured on the completing edge of a reading cycle.
    always_ff @(posedge clk2) begin
        if (!rst_n)                                 rdata <= '0;
        else if (complete && kind_is_read(d_kind)) rdata <= bus_rdata;
    end

    // Write data is driven through every data state of a writing cycle.
    always_comb bus_wen = in_data && kind_is_write(d_kind);

    // R3: address and byte enables hold through a strobed state.
    assert_addr_stable_R3: assert property (@(posedge clk2) disable iff (!rst_n)
        (ads && !phase2) |=> ($stable(bus_addr) && $stable(bus_be)));

    // R7: write data is driven only inside data states.
    assert_wen_in_data_R7: assert property (@(posedge clk2) disable iff (!rst_n)
        bus_wen |-> in_data);

endmodule

// File: rtl/bus_cycle_seq.sv
// Module: bus_cycle_seq (top)
// Two-state bus cycle sequencer: phase divider, state machine, address and
// data records, status decode.
// Assumes: the requester holds a request stable until req_accept.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic                  clk2,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_kind,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  req_lock,
    output logic                  req_accept,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic                  phase2,
    output logic                  ads,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W/8-1:0]   bus_be,
    output logic                  bus_mio,
    output logic                  bus_dc,
    output logic                  bus_wr,
    output logic                  bus_lock,
    input  logic                  bus_ready,
    input  logic                  bus_na,
    input  logic                  bus_hold,
    output logic                  bus_hlda,
    output logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_wen,
    input  logic [DATA_W-1:0]     bus_rdata
);

    localparam int BE_W = DATA_W / 8;

    logic      load_a, load_d, complete, in_data, a_lock, d_lock;
    cyc_kind_t a_kind;

    bus_phase_gen u_phase (
        .clk2   (clk2),
        .rst_n  (rst_n),
        .phase2 (phase2)
    );

    bus_cycle_ctrl u_ctrl (
        .clk2      (clk2),
        .rst_n     (rst_n),
        .phase2    (phase2),
        .req_valid (req_valid),
        .req_lock  (req_lock),
        .ready     (bus_ready),
        .na        (bus_na),
        .hold      (bus_hold),
        .a_lock    (a_lock),
        .d_lock    (d_lock),
        .load_a    (load_a),
        .load_d    (load_d),
        .complete  (complete),
        .in_data   (in_data),
        .ads       (ads),
        .lock      (bus_lock),
        .hlda      (bus_hlda),
        .done      (done)
    );

    bus_cycle_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_dp (
        .clk2      (clk2),
        .rst_n     (rst_n),
        .phase2    (phase2),
        .load_a    (load_a),
        .load_d    (load_d),
        .complete  (complete),
        .in_data   (in_data),
        .ads       (ads),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .req_lock  (req_lock),
        .bus_rdata (bus_rdata),
        .a_kind    (a_kind),
        .a_lock    (a_lock),
        .d_lock    (d_lock),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_wen   (bus_wen),
        .rdata     (rdata)
    );

    bus_status_enc u_enc (
        .kind (a_kind),
        .mio  (bus_mio),
        .dc   (bus_dc),
        .wr   (bus_wr)
    );

    // Accept is the address-side load strobe.
    always_comb req_accept = load_a;

    // R3: an accept happens only at a state end.
    assert_accept_at_state_end_R3: assert property (@(posedge clk2) disable iff (!rst_n)
        req_accept |-> phase2);

endmodule

// File: tb/test_bus_cycle_seq.sv
// Bench for bus_cycle_seq: a state-level expectation model driven by
// seeded random stimulus in segments, with junk inputs during phase one.
module test_bus_cycle_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int N_STATES = 3000;

    localparam int M_IDLE = 0, M_ADDR = 1, M_DATA = 2, M_DNXT = 3, M_HELD = 4;

    logic clk2 = 1'b0;
    logic rst_n;
    logic req_valid, req_lock, req_accept, done, phase2, ads;
    logic [2:0] req_kind;
    logic [AW-1:0] req_addr, bus_addr;
    logic [BW-1:0] req_be, bus_be;
    logic [DW-1:0] req_wdata, rdata, bus_wdata, bus_rdata;
    logic bus_mio, bus_dc, bus_wr, bus_lock, bus_ready, bus_na, bus_hold, bus_hlda, bus_wen;

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) i_bus_cycle_seq (
        .clk2(clk2), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_lock(req_lock),
        .req_accept(req_accept), .done(done), .rdata(rdata), .phase2(phase2), .ads(ads),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_mio(bus_mio), .bus_dc(bus_dc),
        .bus_wr(bus_wr), .bus_lock(bus_lock), .bus_ready(bus_ready), .bus_na(bus_na),
        .bus_hold(bus_hold), .bus_hlda(bus_hlda), .bus_wdata(bus_wdata),
        .bus_wen(bus_wen), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk2 = ~clk2;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expectation model
    int m_st = M_IDLE;
    logic m_lk = 0, m_ads = 0, m_done = 0, acc_last = 0;
    logic [DW-1:0] m_rdata = '0;
    logic [2:0] ma_kind = 3'd0, md_kind = 3'd0;
    logic ma_lock = 0, md_lock = 0;
    logic [AW-1:0] ma_addr = '0;
    logic [BW-1:0] ma_be = '0;
    logic [DW-1:0] ma_wdata = '0, md_wdata = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R4 status table
    function automatic logic [2:0] exp_stat(input logic [2:0] k);
        case (k)
            3'd0: return 3'b110;
            3'd1: return 3'b111;
            3'd2: return 3'b010;
            3'd3: return 3'b011;
            3'd4: return 3'b100;
            3'd5: return 3'b000;
            3'd6: return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    function automatic logic f_wr(input logic [2:0] k);
        return (k == 3'd1) || (k == 3'd3);
    endfunction

    function automatic logic f_rd(input logic [2:0] k);
        return !(f_wr(k) || (k == 3'd6));
    endfunction

    function automatic logic pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    task automatic new_req();
        logic [31:0] t;
        t = $urandom;
        req_valid = 1'b1;
        req_kind  = 3'($urandom % 8);
        req_addr  = t[AW-1:0];
        req_be    = BW'($urandom % 15 + 1);
        req_wdata = $urandom;
        req_lock  = pct(30);
    endtask

    // Drive the sampled inputs in phase two, predict the edge, check accept.
    task automatic phase2_half(input int seg);
        int p_rdy, p_na, p_hold, p_req;
        logic in_d, comp, lka, grant, acc, ld;
        int nst;
        case (seg)
            0: begin p_rdy = 100; p_na = 0;  p_hold = 0;  p_req = 70; end
            1: begin p_rdy = 35;  p_na = 80; p_hold = 0;  p_req = 90; end
            2: begin p_rdy = 60;  p_na = 50; p_hold = 35; p_req = 80; end
            4: begin p_rdy = 50;  p_na = 50; p_hold = 0;  p_req = 0;  end
            default: begin p_rdy = 55; p_na = 40; p_hold = 10; p_req = 60; end
        endcase
        if (!req_valid && pct(p_req)) new_req();
        bus_ready = pct(p_rdy);
        bus_na    = pct(p_na);
        bus_hold  = pct(p_hold);
        bus_rdata = $urandom;
        #1;
        in_d  = (m_st == M_DATA) || (m_st == M_DNXT);
        comp  = in_d && bus_ready;
        lka   = (comp && !md_lock && !((m_st == M_DNXT) && ma_lock)) ? 1'b0 : m_lk;
        grant = bus_hold && !lka;
        acc = 0; ld = 0; nst = m_st;
        case (m_st)
            M_IDLE: if (grant) nst = M_HELD; else if (req_valid) begin acc = 1; nst = M_ADDR; end
            M_ADDR: begin ld = 1; nst = M_DATA; end
            M_DATA: begin
                if (bus_ready) begin
                    if (grant) nst = M_HELD;
                    else if (req_valid) begin acc = 1; nst = M_ADDR; end
                    else nst = M_IDLE;
                end else if (bus_na && req_valid) begin acc = 1; nst = M_DNXT; end
            end
            M_DNXT: if (bus_ready) begin ld = 1; nst = M_DATA; end
            default: if (!bus_hold) nst = M_IDLE;
        endcase
        chk((m_st == M_DNXT || m_st == M_DATA) ? "R8 accept" : "R3 accept", req_accept, acc);
        if (comp && f_rd(md_kind)) m_rdata = bus_rdata;
        m_done = comp;
        m_ads  = acc;
        m_lk   = (acc && req_lock) ? 1'b1 : lka;
        if (ld) begin md_kind = ma_kind; md_lock = ma_lock; md_wdata = ma_wdata; end
        if (acc) begin
            ma_kind = req_kind; ma_lock = req_lock; ma_addr = req_addr;
            ma_be = req_be; ma_wdata = req_wdata;
        end
        m_st = nst;
        acc_last = acc;
    endtask

    // Compare outputs in phase one of the new state, then drive junk.
    task automatic phase1_half();
        logic in_d;
        in_d = (m_st == M_DATA) || (m_st == M_DNXT);
        chk("R1 phase one", phase2, 1'b0);
        chk(m_st == M_DNXT ? "R8 ads" : (m_st == M_IDLE ? "R2 ads idle" : "R3 ads"), ads, m_ads);
        chk("R3 address", bus_addr, ma_addr);
        chk("R3 byte enables", bus_be, ma_be);
        chk("R4 status", {bus_mio, bus_dc, bus_wr}, exp_stat(ma_kind));
        chk("R5 R6 done", done, m_done);
        if (m_done) chk("R6 read data", rdata, m_rdata);
        chk("R7 write enable", bus_wen, in_d && f_wr(md_kind));
        if (in_d && f_wr(md_kind)) chk("R7 write data", bus_wdata, md_wdata);
        chk("R9 lock", bus_lock, m_lk);
        chk("R10 hlda", bus_hlda, m_st == M_HELD);
        chk("R3 no accept in phase one", req_accept, 1'b0);
        if (acc_last) req_valid = 1'b0;
        bus_ready = 1'($urandom);
        bus_na    = 1'($urandom);
        bus_hold  = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'd7341));
        rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_be = 0;
        req_wdata = 0; req_lock = 0; bus_ready = 0; bus_na = 0; bus_hold = 0; bus_rdata = 0;
        repeat (4) @(negedge clk2);
        chk("R2 reset ads", ads, 1'b0);
        chk("R2 reset lock", bus_lock, 1'b0);
        chk("R2 reset hlda", bus_hlda, 1'b0);
        chk("R2 reset done", done, 1'b0);
        chk("R2 reset accept", req_accept, 1'b0);
        chk("R2 reset wen", bus_wen, 1'b0);
        chk("R1 reset phase", phase2, 1'b0);
        rst_n = 1;
        for (int n = 0; n < N_STATES; n++) begin
            int seg;
            seg = (n < 20) ? 4 : (n < 300) ? 0 : (n < 900) ? 1 : (n < 1400) ? 2 : 3;
            @(negedge clk2);
            chk("R1 phase two", phase2, 1'b1);
            phase2_half(seg);
            @(negedge clk2);
            phase1_half();
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk2);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule